// File: doc/BRIEF.md
# Guest Operation Trap Decision Unit

This block sits next to a processor's instruction and system-register access path. For every operation that a guest or the hypervisor issues, it decides one outcome. The operation may run normally, or it may be answered from a hypervisor-owned virtual copy of an identification register. Otherwise it becomes a trap request for the hypervisor level. The operations it handles are wait-for-interrupt, system-register writes and system-register reads. Three plain control pins set the trap behaviour: a wait-for-interrupt trap, a trap on memory-translation configuration writes, and a trap on reads of the memory-feature ID register.

Operations enter on a valid/ready port. An operation is accepted on a rising edge where `op_valid` and `op_ready` are both high. `op_ready` is high whenever the result register is empty or is being drained in the same cycle, so back-pressure on the result port stalls the input port. Each result is registered. It appears one cycle after acceptance and stays unchanged until it is taken with `res_ready`.

The block holds two virtual identification registers: a virtual processor-ID and a virtual affinity value. Neither has a defined reset value. Each has a written flag that reset clears. The hypervisor fills them by writing to them from EL2 or above.

Top module: `vtrap_unit`

## Requirements
- R1: A wait-for-interrupt (`op_kind`=00) issued at EL0 or EL1 while `trap_wfi_en`=1 gives `res_trap`=1 with `res_class`=00 and `res_sleep`=0.
- R2: A wait-for-interrupt that is not trapped gives `res_sleep`=1 and `res_trap`=0.
- R3: While `trap_vm_en`=1, a guest write (`op_kind`=01) to a translation register (register id 3, 4, 5 or 6) gives `res_trap`=1, `res_class`=01, `res_reg` equal to the id, and `res_we`=0.
- R4: Reads (`op_kind`=10) of translation registers are never trapped. An untrapped write to any other register id (3 to 6, or 9 to 15) gives `res_we`=1 with `res_wdata` equal to the written data. Reads of those ids give `res_rdvalid`=0.
- R5: While `trap_idrd_en`=1, a guest read of the memory-feature ID register (id 2) gives `res_trap`=1 and `res_class`=10. Otherwise that read returns the physical memory-feature value with `res_rdvalid`=1.
- R6: A read of the processor-ID register (id 0) is never trapped. At EL0 or EL1 it returns the virtual processor-ID (id 7). At EL2 or above it returns the physical value.
- R7: A read of the affinity register (id 1) is never trapped. At EL0 or EL1 it returns the virtual affinity (id 8). At EL2 or above it returns the physical value.
- R8: Both `vid_init` bits are 0 after reset. An EL2-or-above write to id 7 or id 8 stores the data and sets `vid_init` bit 0 or bit 1 respectively. Guest writes to ids 7 and 8 change nothing. Writes to ids 0 to 2 have no effect.
- R9: No operation issued at EL2 or above is ever trapped.
- R10: Each result carries at most one outcome. When `res_trap`=1, `res_sleep`, `res_we` and `res_rdvalid` are all 0.
- R11: The result appears on the cycle after acceptance. `op_ready` equals `!res_valid || res_ready`. While `res_valid`=1 and `res_ready`=0, every result field holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_wfi_en | input | 1 | Trap guest wait-for-interrupt |
| trap_vm_en | input | 1 | Trap guest writes to translation registers |
| trap_idrd_en | input | 1 | Trap guest reads of the memory-feature ID register |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Operation can be accepted |
| op_el | input | 2 | Exception level of the issuer |
| op_kind | input | 2 | 00 wait-for-interrupt, 01 write, 10 read, 11 no-op |
| op_reg | input | REG_W | Register identifier |
| op_wdata | input | DATA_W | Write data |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken |
| res_trap | output | 1 | Trap to hypervisor level requested |
| res_class | output | 2 | Trap class: 00 wait, 01 write, 10 read |
| res_reg | output | REG_W | Register identifier of the operation |
| res_sleep | output | 1 | Low-power request |
| res_rdvalid | output | 1 | `res_rdata` is supplied by this block |
| res_rdata | output | DATA_W | Read data for identification registers |
| res_we | output | 1 | Write enable for the real register |
| res_wdata | output | DATA_W | Data for the real register write |
| vid_init | output | 2 | Virtual processor-ID / affinity written flags |

## Verification
Two functions can meet in adjacent cycles. A hypervisor write can update a virtual register on the same edge that a guest read of the matching identification register is being decided. The bench provokes this by holding `res_ready` high and issuing an EL2 write to id 7 immediately followed by an EL1 read of id 0. It then judges that the read returns the newly written value, not the old one. Stalls with `res_ready` low are interleaved with random operations to check that results hold and that the input side stops.

// File: rtl/vtrap_pkg.sv
package vtrap_pkg;

  typedef enum logic [1:0] {
    OP_WFI  = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b10,
    OP_NONE = 2'b11
  } op_kind_e;

  localparam logic [1:0] CLS_WFI = 2'b00;
  localparam logic [1:0] CLS_WR  = 2'b01;
  localparam logic [1:0] CLS_RD  = 2'b10;

  // register identifiers
  localparam int unsigned ID_CPUID   = 0;
  localparam int unsigned ID_AFFIN   = 1;
  localparam int unsigned ID_MEMFEAT = 2;
  localparam int unsigned ID_MMU_LO  = 3;
  localparam int unsigned ID_MMU_HI  = 6;
  localparam int unsigned ID_VCPUID  = 7;
  localparam int unsigned ID_VAFFIN  = 8;

  localparam int unsigned NUM_VREG = 2;
  localparam int unsigned VSEL_W   = $clog2(NUM_VREG);

  typedef struct packed {
    logic              guest;
    logic              is_mmu;
    logic              is_memfeat;
    logic              is_cpuid;
    logic              is_affin;
    logic              is_vreg;
    logic [VSEL_W-1:0] vsel;
    logic              is_ro;
  } reg_class_t;

  typedef struct packed {
    logic              trap;
    logic [1:0]        cls;
    logic              sleep;
    logic              rdvalid;
    logic              we;
    logic              vwr;
    logic [VSEL_W-1:0] vsel;
  } decision_t;

endpackage

// File: rtl/vtrap_classify.sv
module vtrap_classify
  import vtrap_pkg::*;
#(
  parameter int unsigned REG_W = 4
) (
  input  logic [1:0]       el,
  input  logic [REG_W-1:0] reg_id,
  output reg_class_t       rc
);
  always_comb begin
    rc            = '0;
    rc.guest      = (el < 2'd2);
    rc.is_cpuid   = (reg_id == REG_W'(ID_CPUID));
    rc.is_affin   = (reg_id == REG_W'(ID_AFFIN));
    rc.is_memfeat = (reg_id == REG_W'(ID_MEMFEAT));
    rc.is_mmu     = (reg_id >= REG_W'(ID_MMU_LO)) && (reg_id <= REG_W'(ID_MMU_HI));
    rc.is_vreg    = (reg_id == REG_W'(ID_VCPUID)) || (reg_id == REG_W'(ID_VAFFIN));
    rc.vsel       = VSEL_W'(reg_id == REG_W'(ID_VAFFIN));
    rc.is_ro      = rc.is_cpuid || rc.is_affin || rc.is_memfeat;
  end
endmodule

// File: rtl/vtrap_vregs.sv
module vtrap_vregs
  import vtrap_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [VSEL_W-1:0]                wr_sel,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_VREG-1:0][DATA_W-1:0]  val,
  output logic [NUM_VREG-1:0]              written
);
  for (genvar i = 0; i < NUM_VREG; i++) begin : g_vreg
    logic hit;
    assign hit = wr_en && (wr_sel == VSEL_W'(i));

    // contents have no defined reset value
    always_ff @(posedge clk) begin
      if (hit) val[i] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   written[i] <= 1'b0;
      else if (hit) written[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/vtrap_decide.sv
module vtrap_decide
  import vtrap_pkg::*;
#(
  parameter int unsigned             DATA_W       = 64,
  parameter logic [DATA_W-1:0]       PHYS_CPUID   = '0,
  parameter logic [DATA_W-1:0]       PHYS_AFFIN   = '0,
  parameter logic [DATA_W-1:0]       PHYS_MEMFEAT = '0
) (
  input  logic [1:0]                       kind,
  input  reg_class_t                       rc,
  input  logic                             trap_wfi_en,
  input  logic                             trap_vm_en,
  input  logic                             trap_idrd_en,
  input  logic [NUM_VREG-1:0][DATA_W-1:0]  vval,
  output decision_t                        dec,
  output logic [DATA_W-1:0]                rdata
);
  always_comb begin
    dec   = '0;
    rdata = '0;
    unique case (op_kind_e'(kind))
      OP_WFI: begin
        if (rc.guest && trap_wfi_en) begin
          dec.trap = 1'b1;
          dec.cls  = CLS_WFI;
        end else begin
          dec.sleep = 1'b1;
        end
      end
      OP_WR: begin
        if (rc.guest && trap_vm_en && rc.is_mmu) begin
          dec.trap = 1'b1;
          dec.cls  = CLS_WR;
        end else if (rc.is_vreg) begin
          dec.vwr  = !rc.guest;
          dec.vsel = rc.vsel;
        end else if (!rc.is_ro) begin
          dec.we = 1'b1;
        end
      end
      OP_RD: begin
        if (rc.guest && trap_idrd_en && rc.is_memfeat) begin
          dec.trap = 1'b1;
          dec.cls  = CLS_RD;
        end else if (rc.is_cpuid) begin
          dec.rdvalid = 1'b1;
          rdata       = rc.guest ? vval[0] : PHYS_CPUID;
        end else if (rc.is_affin) begin
          dec.rdvalid = 1'b1;
          rdata       = rc.guest ? vval[1] : PHYS_AFFIN;
        end else if (rc.is_memfeat) begin
          dec.rdvalid = 1'b1;
          rdata       = PHYS_MEMFEAT;
        end else if (rc.is_vreg) begin
          dec.rdvalid = 1'b1;
          rdata       = rc.guest ? '0 : vval[rc.vsel];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vtrap_unit.sv
module vtrap_unit
  import vtrap_pkg::*;
#(
  parameter int unsigned       DATA_W       = 64,
  parameter int unsigned       REG_W        = 4,
  parameter logic [DATA_W-1:0] PHYS_CPUID   = DATA_W'(64'h0000_0000_410F_D034),
  parameter logic [DATA_W-1:0] PHYS_AFFIN   = DATA_W'(64'h0000_0000_8000_0102),
  parameter logic [DATA_W-1:0] PHYS_MEMFEAT = DATA_W'(64'h0000_0000_0000_1122)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_wfi_en,
  input  logic              trap_vm_en,
  input  logic              trap_idrd_en,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_el,
  input  logic [1:0]        op_kind,
  input  logic [REG_W-1:0]  op_reg,
  input  logic [DATA_W-1:0] op_wdata,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_trap,
  output logic [1:0]        res_class,
  output logic [REG_W-1:0]  res_reg,
  output logic              res_sleep,
  output logic              res_rdvalid,
  output logic [DATA_W-1:0] res_rdata,
  output logic              res_we,
  output logic [DATA_W-1:0] res_wdata,
  output logic [1:0]        vid_init
);
  reg_class_t                      rc;
  decision_t                       dec;
  logic [DATA_W-1:0]               dec_rdata;
  logic [NUM_VREG-1:0][DATA_W-1:0] vval;
  logic [NUM_VREG-1:0]             vwritten;
  logic                            accept;

  assign op_ready = !res_valid || res_ready;
  assign accept   = op_valid && op_ready;
  assign vid_init = vwritten;

  vtrap_classify #(.REG_W(REG_W)) u_classify (
    .el     (op_el),
    .reg_id (op_reg),
    .rc     (rc)
  );

  vtrap_decide #(
    .DATA_W       (DATA_W),
    .PHYS_CPUID   (PHYS_CPUID),
    .PHYS_AFFIN   (PHYS_AFFIN),
    .PHYS_MEMFEAT (PHYS_MEMFEAT)
  ) u_decide (
    .kind         (op_kind),
    .rc           (rc),
    .trap_wfi_en  (trap_wfi_en),
    .trap_vm_en   (trap_vm_en),
    .trap_idrd_en (trap_idrd_en),
    .vval         (vval),
    .dec          (dec),
    .rdata        (dec_rdata)
  );

  vtrap_vregs #(.DATA_W(DATA_W)) u_vregs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept && dec.vwr),
    .wr_sel  (dec.vsel),
    .wr_data (op_wdata),
    .val     (vval),
    .written (vwritten)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_trap    <= 1'b0;
      res_class   <= '0;
      res_reg     <= '0;
      res_sleep   <= 1'b0;
      res_rdvalid <= 1'b0;
      res_rdata   <= '0;
      res_we      <= 1'b0;
      res_wdata   <= '0;
    end else if (accept) begin
      res_valid   <= 1'b1;
      res_trap    <= dec.trap;
      res_class   <= dec.cls;
      res_reg     <= op_reg;
      res_sleep   <= dec.sleep;
      res_rdvalid <= dec.rdvalid;
      res_rdata   <= dec_rdata;
      res_we      <= dec.we;
      res_wdata   <= op_wdata;
    end else if (res_ready) begin
      res_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/vtrap_checker.sv
module vtrap_checker #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned REG_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [1:0]        op_el,
  input logic [1:0]        op_kind,
  input logic [REG_W-1:0]  op_reg,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_trap,
  input logic [1:0]        res_class,
  input logic              res_sleep,
  input logic              res_rdvalid,
  input logic [DATA_W-1:0] res_rdata,
  input logic              res_we,
  input logic [1:0]        vid_init
);
  logic acc, mmu_reg;
  assign acc     = op_valid && op_ready;
  assign mmu_reg = (op_reg >= REG_W'(3)) && (op_reg <= REG_W'(6));

  AST_WFI_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_kind == 2'b00 |=> res_trap != res_sleep); // R2
  AST_MMU_READ_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_kind == 2'b10 && mmu_reg |=> !res_trap); // R4
  AST_VID0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    vid_init[0] |=> vid_init[0]); // R8
  AST_VID1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    vid_init[1] |=> vid_init[1]); // R8
  AST_HYP_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_el >= 2'd2 |=> !res_trap); // R9
  AST_TRAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_trap |-> !res_sleep && !res_we && !res_rdvalid); // R10
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_trap) && $stable(res_class)
      && $stable(res_rdata) && $stable(res_we) && $stable(res_sleep)); // R11
endmodule

bind vtrap_unit vtrap_checker #(.DATA_W(DATA_W), .REG_W(REG_W)) u_vtrap_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .op_ready    (op_ready),
  .op_el       (op_el),
  .op_kind     (op_kind),
  .op_reg      (op_reg),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_trap    (res_trap),
  .res_class   (res_class),
  .res_sleep   (res_sleep),
  .res_rdvalid (res_rdvalid),
  .res_rdata   (res_rdata),
  .res_we      (res_we),
  .vid_init    (vid_init)
);

// File: tb/vtrap_unit_bench.sv
module vtrap_unit_bench;
  localparam int unsigned DW = 64;
  localparam int unsigned RW = 4;
  localparam logic [DW-1:0] P_CPU = 64'h0000_0000_410F_D034;
  localparam logic [DW-1:0] P_AFF = 64'h0000_0000_8000_0102;
  localparam logic [DW-1:0] P_MEM = 64'h0000_0000_0000_1122;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_wfi_en = 0, trap_vm_en = 0, trap_idrd_en = 0;
  logic op_valid = 0, res_ready = 0;
  logic op_ready;
  logic [1:0] op_el = 0, op_kind = 2'b11;
  logic [RW-1:0] op_reg = 0;
  logic [DW-1:0] op_wdata = 0;
  logic res_valid, res_trap, res_sleep, res_rdvalid, res_we;
  logic [1:0] res_class, vid_init;
  logic [RW-1:0] res_reg;
  logic [DW-1:0] res_rdata, res_wdata;

  int total = 0, fails = 0;
  logic [DW-1:0] m_vcpu = '0, m_vaff = '0;

  typedef struct packed {
    logic trap; logic [1:0] cls; logic sleep; logic rdv; logic we; logic [DW-1:0] rdata;
  } exp_t;

  always #5 clk = ~clk;

  vtrap_unit #(.DATA_W(DW), .REG_W(RW), .PHYS_CPUID(P_CPU), .PHYS_AFFIN(P_AFF),
               .PHYS_MEMFEAT(P_MEM)) u_vtrap_unit (
    .clk(clk), .rst_n(rst_n), .trap_wfi_en(trap_wfi_en), .trap_vm_en(trap_vm_en),
    .trap_idrd_en(trap_idrd_en), .op_valid(op_valid), .op_ready(op_ready), .op_el(op_el),
    .op_kind(op_kind), .op_reg(op_reg), .op_wdata(op_wdata), .res_valid(res_valid),
    .res_ready(res_ready), .res_trap(res_trap), .res_class(res_class), .res_reg(res_reg),
    .res_sleep(res_sleep), .res_rdvalid(res_rdvalid), .res_rdata(res_rdata), .res_we(res_we),
    .res_wdata(res_wdata), .vid_init(vid_init));

  function automatic exp_t model(logic [1:0] el, logic [1:0] k, logic [RW-1:0] r);
    exp_t e = '0;
    logic g = (el < 2);
    case (k)
      2'b00: if (g && trap_wfi_en) e.trap = 1; else e.sleep = 1;
      2'b01: if (g && trap_vm_en && r >= 3 && r <= 6) begin e.trap = 1; e.cls = 2'b01; end
             else if (!(r <= 2 || r == 7 || r == 8)) e.we = 1;
      2'b10: if (g && trap_idrd_en && r == 2) begin e.trap = 1; e.cls = 2'b10; end
             else if (r == 0) begin e.rdv = 1; e.rdata = g ? m_vcpu : P_CPU; end
             else if (r == 1) begin e.rdv = 1; e.rdata = g ? m_vaff : P_AFF; end
             else if (r == 2) begin e.rdv = 1; e.rdata = P_MEM; end
             else if (r == 7) begin e.rdv = 1; e.rdata = g ? '0 : m_vcpu; end
             else if (r == 8) begin e.rdv = 1; e.rdata = g ? '0 : m_vaff; end
      default: ;
    endcase
    return e;
  endfunction

  function automatic string tag_of(logic [1:0] el, logic [1:0] k, logic [RW-1:0] r);
    if (el >= 2 && k != 2'b11) return "R9";
    case (k)
      2'b00: return trap_wfi_en ? "R1" : "R2";
      2'b01: return (r == 7 || r == 8 || r <= 2) ? "R8" : (trap_vm_en && r >= 3 && r <= 6) ? "R3" : "R4";
      2'b10: return r == 0 ? "R6" : r == 1 ? "R7" : r == 2 ? "R5" : "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_res(exp_t e, string req, logic [RW-1:0] r, logic [DW-1:0] wd);
    bit ok;
    ok = res_valid && res_trap == e.trap && res_sleep == e.sleep && res_we == e.we &&
         res_rdvalid == e.rdv && (!e.trap || (res_class == e.cls && res_reg == r)) &&
         (!e.we || res_wdata == wd) && (!e.rdv || res_rdata == e.rdata);
    check(ok, req, "result {valid,trap,cls,sleep,rdv,we}/rdata",
          {res_valid, res_trap, res_class, res_sleep, res_rdvalid, res_we, res_rdata[56:0]},
          {1'b1, e.trap, e.cls, e.sleep, e.rdv, e.we, e.rdata[56:0]});
  endtask

  task automatic do_op(logic [1:0] el, logic [1:0] k, logic [RW-1:0] r, logic [DW-1:0] wd, int stall);
    exp_t e;
    string req;
    @(negedge clk);
    op_el = el; op_kind = k; op_reg = r; op_wdata = wd; op_valid = 1; res_ready = 0;
    e = model(el, k, r);
    req = tag_of(el, k, r);
    if (k == 2'b01 && el >= 2 && r == 7) m_vcpu = wd;
    if (k == 2'b01 && el >= 2 && r == 8) m_vaff = wd;
    @(negedge clk);
    op_valid = 0;
    check_res(e, req, r, wd);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check_res(e, "R11", r, wd);
      check(op_ready == 0, "R11", "op_ready during stall", DW'(op_ready), 0);
    end
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    check(res_valid == 0, "R11", "res_valid after drain", DW'(res_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    exp_t e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(res_valid == 0, "R11", "res_valid after reset", DW'(res_valid), 0);
    check(op_ready == 1, "R11", "op_ready after reset", DW'(op_ready), 1);
    check(vid_init == 0, "R8", "vid_init after reset", DW'(vid_init), 0);

    // guest writes to virtual registers are ignored
    do_op(2'd1, 2'b01, 4'd7, 64'hDEAD, 0);
    check(vid_init == 0, "R8", "vid_init after guest write", DW'(vid_init), 0);
    // hypervisor initialises virtual registers
    do_op(2'd2, 2'b01, 4'd7, 64'h0000_0000_AAAA_0001, 0);
    check(vid_init == 2'b01, "R8", "vid_init after vcpu write", DW'(vid_init), 1);
    do_op(2'd3, 2'b01, 4'd8, 64'h0000_0000_BBBB_0002, 1);
    check(vid_init == 2'b11, "R8", "vid_init after vaff write", DW'(vid_init), 3);
    do_op(2'd1, 2'b01, 4'd8, 64'h1234, 0);          // ignored guest write
    do_op(2'd1, 2'b10, 4'd1, '0, 0);                // R7 sees unchanged value
    do_op(2'd0, 2'b10, 4'd0, '0, 0);                // R6 virtual
    do_op(2'd2, 2'b10, 4'd0, '0, 0);                // R6 physical
    do_op(2'd2, 2'b10, 4'd1, '0, 0);                // R7 physical
    do_op(2'd2, 2'b01, 4'd0, 64'h55, 0);            // write to read-only id (R8)
    do_op(2'd2, 2'b10, 4'd0, '0, 0);
    trap_wfi_en = 1; trap_vm_en = 1; trap_idrd_en = 1;
    do_op(2'd0, 2'b00, 4'd0, '0, 2);                // R1
    do_op(2'd2, 2'b00, 4'd0, '0, 0);                // R9
    do_op(2'd1, 2'b01, 4'd4, 64'h77, 0);            // R3
    do_op(2'd1, 2'b10, 4'd5, '0, 0);                // R4 read not trapped
    do_op(2'd1, 2'b10, 4'd2, '0, 0);                // R5 trap
    do_op(2'd2, 2'b01, 4'd6, 64'h99, 0);            // R9 write allowed
    trap_wfi_en = 0; trap_idrd_en = 0;
    do_op(2'd1, 2'b00, 4'd0, '0, 0);                // R2
    do_op(2'd1, 2'b10, 4'd2, '0, 0);                // R5 physical

    // back-to-back: hypervisor update then guest read with no gap
    @(negedge clk);
    res_ready = 1; op_valid = 1;
    op_el = 2'd2; op_kind = 2'b01; op_reg = 4'd7; op_wdata = 64'h0000_0000_CCCC_0003;
    m_vcpu = op_wdata;
    @(negedge clk);
    check(res_valid && !res_trap && !res_we, "R8", "vcpu write result", DW'(res_valid), 1);
    op_el = 2'd1; op_kind = 2'b10; op_reg = 4'd0;
    e = model(2'd1, 2'b10, 4'd0);
    @(negedge clk);
    op_valid = 0;
    check_res(e, "R6", 4'd0, '0);
    @(negedge clk);
    res_ready = 0;

    // constrained random
    for (int n = 0; n < 300; n++) begin
      logic [1:0] el, k;
      logic [RW-1:0] r;
      logic [DW-1:0] wd;
      trap_wfi_en = 1'($urandom); trap_vm_en = 1'($urandom); trap_idrd_en = 1'($urandom);
      el = 2'($urandom); k = 2'($urandom); r = RW'($urandom_range(0, 10));
      wd = {$urandom, $urandom};
      do_op(el, k, r, wd, int'($urandom_range(0, 2)));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule